// File: doc/BRIEF.md
# Indexed Load/Store Address Generator

This block turns the operands of a single-register load or store into the values the memory pipeline needs. It takes a base register, a register offset, an immediate field and a five-bit indexing control. In one registered stage it produces the effective address, the base-register writeback enable and value, the access size and whether loaded data must be sign-extended. Pre- and post-indexing, adding or subtracting the offset, and writeback share one adder. The subtract case feeds the adder the two's-complement negation of the offset.

Two operand families exist. In the word/byte family a separate select picks between a register offset and a 12-bit immediate, and control bit 2 selects byte size. In the halfword/signed family control bit 2 picks an 8-bit immediate instead of the register offset, and a two-bit kind code gives the data type.

A second, independent path takes a raw memory word on load return. It extracts the addressed byte or halfword lane, zero- or sign-extends it, and registers it.

Both paths are valid/ready streams with one register stage each. A stage accepts input when it is empty or when its output is taken in the same cycle. An output held under back-pressure stays valid and unchanged until it is taken. The two paths never stall each other.

Top module: `ls_addr_gen`

## Requirements
- R1: Control bit positions are: bit 4 pre-index, bit 3 up, bit 2 immediate/byte select, bit 1 writeback, bit 0 load. With bit 4 = 0 (post-index) the address is the unmodified base, writeback is always enabled, and the writeback value is base plus or minus the offset.
- R2: With bit 4 = 1 (pre-index) the address equals base plus or minus the offset. Writeback is enabled only when bit 1 = 1, and the writeback value always equals that same sum.
- R3: With bit 3 = 0 the offset is subtracted, and with bit 3 = 1 it is added. Results wrap modulo 2^AW.
- R4: In the word/byte family (family input 0), the register-select input picks between the register offset (1) and the 12-bit immediate zero-extended (0). Bit 2 = 1 gives a byte access and bit 2 = 0 a word access. Size codes are 0 byte, 1 halfword and 2 word.
- R5: In the halfword/signed family (family input 1), bit 2 = 1 uses an 8-bit immediate made from immediate bits [11:8] as the high nibble and [3:0] as the low nibble. Immediate bits [7:4] have no effect. Bit 2 = 0 uses the register offset.
- R6: Kind codes in the halfword/signed family are: 0 and 1 unsigned halfword (size 1), 2 signed byte (size 0), 3 signed halfword (size 1). The sign-extend output is 1 only for a load (bit 0 = 1) of kind 2 or 3. The load output repeats bit 0.
- R7: A request is answered one cycle after it is accepted. Request ready equals "response not valid or response ready". A stalled response holds all its fields.
- R8: On the load path a byte is taken from lane ld_lane_i (bits 8*lane+7 down to 8*lane) and a halfword from lane pair ld_lane_i[1]. A word passes unchanged. With the sign-extend input 0 the upper bits are zero.
- R9: With the sign-extend input 1, a byte load copies its bit 7 into all higher bits and a halfword load copies its bit 15.
- R10: The load path follows the same one-cycle, hold-under-stall rules, independently of the request path. Both paths may accept in the same cycle.
- R11: During reset both output valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_base_i | input | AW | Base register value |
| req_roff_i | input | AW | Register offset |
| req_imm_i | input | 12 | Immediate field |
| req_ctrl_i | input | 5 | Indexing control (R1) |
| req_fam_i | input | 1 | 0 word/byte family, 1 halfword/signed family |
| req_kind_i | input | 2 | Data kind for family 1 (R6) |
| req_rsel_i | input | 1 | Register offset select for family 0 |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response ready |
| rsp_addr_o | output | AW | Effective address |
| rsp_wb_en_o | output | 1 | Base writeback enable |
| rsp_wb_val_o | output | AW | Base writeback value |
| rsp_size_o | output | 2 | Access size code |
| rsp_sext_o | output | 1 | Sign-extend loaded data |
| rsp_load_o | output | 1 | Access is a load |
| ld_valid_i | input | 1 | Load return valid |
| ld_ready_o | output | 1 | Load return ready |
| ld_word_i | input | DW | Raw memory word |
| ld_lane_i | input | 2 | Byte lane of the access |
| ld_size_i | input | 2 | Access size code |
| ld_sext_i | input | 1 | Sign-extend select |
| ldo_valid_o | output | 1 | Extended data valid |
| ldo_ready_i | input | 1 | Extended data ready |
| ldo_data_o | output | DW | Extended load data |

## Verification
The address path and the load-return path can both accept in the same clock edge. A directed test raises both input valids in one cycle. It then checks that each output carries its own expected result one cycle later, with neither ready dropped. A second directed case stalls the response while a new request waits. It confirms that the held fields stay put and that the waiting request enters on the same edge the held one leaves.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;
  localparam int CB_LOAD = 0;
  localparam int CB_WB   = 1;
  localparam int CB_SEL  = 2;
  localparam int CB_UP   = 3;
  localparam int CB_PRE  = 4;
  localparam int CTRL_W  = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    EK_UHALF_ALT = 2'd0,
    EK_UHALF     = 2'd1,
    EK_SBYTE     = 2'd2,
    EK_SHALF     = 2'd3
  } ext_kind_e;
endpackage

// File: rtl/agu_offset_sel.sv
module agu_offset_sel #(
  parameter int AW    = 32,
  parameter int IMM_W = 12,
  parameter int NIB_W = 4
) (
  input  logic             ext_fam,
  input  logic             sel_bit,
  input  logic             roff_sel,
  input  logic [AW-1:0]    roff,
  input  logic [IMM_W-1:0] imm,
  output logic [AW-1:0]    off
);
  localparam int SPLIT_W = 2 * NIB_W;

  logic [SPLIT_W-1:0] split_imm;
  logic [AW-1:0]      wide_imm;
  logic [AW-1:0]      wide_split;

  assign split_imm  = {imm[IMM_W-1 -: NIB_W], imm[NIB_W-1:0]};
  assign wide_imm   = {{(AW-IMM_W){1'b0}}, imm};
  assign wide_split = {{(AW-SPLIT_W){1'b0}}, split_imm};

  always_comb begin
    if (ext_fam) off = sel_bit ? wide_split : roff;
    else         off = roff_sel ? roff : wide_imm;
  end
endmodule

// File: rtl/agu_addr_core.sv
module agu_addr_core
  import ls_agu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]     base,
  input  logic [AW-1:0]     off,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              ext_fam,
  input  logic [1:0]        kind,
  output logic [AW-1:0]     addr,
  output logic              wb_en,
  output logic [AW-1:0]     wb_val,
  output logic [1:0]        size,
  output logic              sext,
  output logic              load
);
  logic [AW-1:0] signed_off;
  logic [AW-1:0] sum;
  ext_kind_e     ek;
  acc_size_e     sz;

  assign signed_off = ctrl[CB_UP] ? off : (~off + {{(AW-1){1'b0}}, 1'b1});
  assign sum        = base + signed_off;
  assign addr       = ctrl[CB_PRE] ? sum : base;
  assign wb_en      = ~ctrl[CB_PRE] | ctrl[CB_WB];
  assign wb_val     = sum;
  assign load       = ctrl[CB_LOAD];
  assign ek         = ext_kind_e'(kind);

  always_comb begin
    if (ext_fam) begin
      unique case (ek)
        EK_SBYTE: sz = SZ_BYTE;
        default:  sz = SZ_HALF;
      endcase
      sext = ctrl[CB_LOAD] & ((ek == EK_SBYTE) | (ek == EK_SHALF));
    end else begin
      sz   = ctrl[CB_SEL] ? SZ_BYTE : SZ_WORD;
      sext = 1'b0;
    end
  end

  assign size = sz;
endmodule

// File: rtl/agu_load_extend.sv
module agu_load_extend
  import ls_agu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]            word,
  input  logic [$clog2(DW/8)-1:0]  lane,
  input  logic [1:0]               size,
  input  logic                     sext,
  output logic [DW-1:0]            data
);
  localparam int LANES  = DW / 8;
  localparam int HALVES = DW / 16;
  localparam int LW     = $clog2(LANES);

  logic [7:0]  bytes  [LANES];
  logic [15:0] halves [HALVES];

  for (genvar i = 0; i < LANES; i++) begin : g_byte
    assign bytes[i] = word[8*i +: 8];
  end
  for (genvar j = 0; j < HALVES; j++) begin : g_half
    assign halves[j] = word[16*j +: 16];
  end

  logic [7:0]  b_sel;
  logic [15:0] h_sel;

  assign b_sel = bytes[lane];
  assign h_sel = halves[lane[LW-1:1]];

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE: data = {{(DW-8){sext & b_sel[7]}}, b_sel};
      SZ_HALF: data = {{(DW-16){sext & h_sel[15]}}, h_sel};
      default: data = word;
    endcase
  end
endmodule

// File: rtl/agu_stage.sv
module agu_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
  import ls_agu_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IMM_W = 12,
  parameter int NIB_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [AW-1:0]     req_base_i,
  input  logic [AW-1:0]     req_roff_i,
  input  logic [IMM_W-1:0]  req_imm_i,
  input  logic [CTRL_W-1:0] req_ctrl_i,
  input  logic              req_fam_i,
  input  logic [1:0]        req_kind_i,
  input  logic              req_rsel_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [AW-1:0]     rsp_addr_o,
  output logic              rsp_wb_en_o,
  output logic [AW-1:0]     rsp_wb_val_o,
  output logic [1:0]        rsp_size_o,
  output logic              rsp_sext_o,
  output logic              rsp_load_o,
  input  logic              ld_valid_i,
  output logic              ld_ready_o,
  input  logic [DW-1:0]     ld_word_i,
  input  logic [$clog2(DW/8)-1:0] ld_lane_i,
  input  logic [1:0]        ld_size_i,
  input  logic              ld_sext_i,
  output logic              ldo_valid_o,
  input  logic              ldo_ready_i,
  output logic [DW-1:0]     ldo_data_o
);
  localparam int RSP_W = 2*AW + 5;

  logic [AW-1:0] off;
  logic [AW-1:0] c_addr, c_wbval;
  logic          c_wben, c_sext, c_load;
  logic [1:0]    c_size;
  logic [DW-1:0] ext_data;

  agu_offset_sel #(.AW(AW), .IMM_W(IMM_W), .NIB_W(NIB_W)) u_off (
    .ext_fam (req_fam_i),
    .sel_bit (req_ctrl_i[CB_SEL]),
    .roff_sel(req_rsel_i),
    .roff    (req_roff_i),
    .imm     (req_imm_i),
    .off     (off)
  );

  agu_addr_core #(.AW(AW)) u_core (
    .base   (req_base_i),
    .off    (off),
    .ctrl   (req_ctrl_i),
    .ext_fam(req_fam_i),
    .kind   (req_kind_i),
    .addr   (c_addr),
    .wb_en  (c_wben),
    .wb_val (c_wbval),
    .size   (c_size),
    .sext   (c_sext),
    .load   (c_load)
  );

  agu_stage #(.W(RSP_W)) u_rsp_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid_i),
    .in_ready (req_ready_o),
    .in_data  ({c_addr, c_wben, c_wbval, c_size, c_sext, c_load}),
    .out_valid(rsp_valid_o),
    .out_ready(rsp_ready_i),
    .out_data ({rsp_addr_o, rsp_wb_en_o, rsp_wb_val_o, rsp_size_o, rsp_sext_o, rsp_load_o})
  );

  agu_load_extend #(.DW(DW)) u_ext (
    .word(ld_word_i),
    .lane(ld_lane_i),
    .size(ld_size_i),
    .sext(ld_sext_i),
    .data(ext_data)
  );

  agu_stage #(.W(DW)) u_ld_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (ld_valid_i),
    .in_ready (ld_ready_o),
    .in_data  (ext_data),
    .out_valid(ldo_valid_o),
    .out_ready(ldo_ready_i),
    .out_data (ldo_data_o)
  );
endmodule

// File: rtl/ls_addr_gen_sva.sv
module ls_addr_gen_sva #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IMM_W = 12,
  parameter int NIB_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [AW-1:0]     req_base_i,
  input logic [AW-1:0]     req_roff_i,
  input logic [IMM_W-1:0]  req_imm_i,
  input logic [4:0]        req_ctrl_i,
  input logic              req_fam_i,
  input logic [1:0]        req_kind_i,
  input logic              req_rsel_i,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [AW-1:0]     rsp_addr_o,
  input logic              rsp_wb_en_o,
  input logic [AW-1:0]     rsp_wb_val_o,
  input logic [1:0]        rsp_size_o,
  input logic              rsp_sext_o,
  input logic              rsp_load_o,
  input logic              ld_valid_i,
  input logic              ld_ready_o,
  input logic [DW-1:0]     ld_word_i,
  input logic [$clog2(DW/8)-1:0] ld_lane_i,
  input logic [1:0]        ld_size_i,
  input logic              ld_sext_i,
  input logic              ldo_valid_o,
  input logic              ldo_ready_i,
  input logic [DW-1:0]     ldo_data_o
);
  logic req_acc, ld_acc;
  assign req_acc = req_valid_i & req_ready_o;
  assign ld_acc  = ld_valid_i & ld_ready_o;

  p_post_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_acc && !req_ctrl_i[4] |=> rsp_valid_o && rsp_wb_en_o && rsp_addr_o == $past(req_base_i));

  p_pre_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_acc && req_ctrl_i[4] |=> rsp_wb_en_o == $past(req_ctrl_i[1]) && rsp_addr_o == rsp_wb_val_o);

  p_store_nosext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_load_o |-> !rsp_sext_o);

  p_stall_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_ready_i |-> !req_ready_o);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_addr_o) && $stable(rsp_wb_val_o)
      && $stable(rsp_wb_en_o) && $stable(rsp_size_o));

  p_byte_sext_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_acc && ld_size_i == 2'd0 && ld_sext_i |=> ldo_data_o[DW-1:8] == {(DW-8){ldo_data_o[7]}});

  p_ld_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ldo_valid_o && !ldo_ready_i |=> ldo_valid_o && $stable(ldo_data_o));
endmodule

bind ls_addr_gen ls_addr_gen_sva #(.AW(AW), .DW(DW), .IMM_W(IMM_W), .NIB_W(NIB_W)) u_sva (.*);

// File: tb/ls_addr_gen_bench.sv
module ls_addr_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] roff;
    logic [11:0] imm;
    logic [4:0]  ctrl;
    logic        fam;
    logic [1:0]  kind;
    logic        rsel;
    logic [31:0] e_addr;
    logic        e_wben;
    logic [31:0] e_wbval;
    logic [1:0]  e_size;
    logic        e_sext;
    logic        e_load;
  } rv_t;

  localparam int NR = 8;
  localparam rv_t RTBL [NR] = '{
    '{32'h1000, 32'h10, 12'h000, 5'h19, 1'b0, 2'd0, 1'b1, 32'h1010, 1'b0, 32'h1010, 2'd2, 1'b0, 1'b1},
    '{32'h2000, 32'h99, 12'h123, 5'h00, 1'b0, 2'd0, 1'b0, 32'h2000, 1'b1, 32'h1EDD, 2'd2, 1'b0, 1'b0},
    '{32'h0100, 32'h00, 12'h0FF, 5'h17, 1'b0, 2'd0, 1'b0, 32'h0001, 1'b1, 32'h0001, 2'd0, 1'b0, 1'b1},
    '{32'h4000, 32'h77, 12'hAF5, 5'h1D, 1'b1, 2'd3, 1'b0, 32'h40A5, 1'b0, 32'h40A5, 2'd1, 1'b1, 1'b1},
    '{32'h0010, 32'h20, 12'hFFF, 5'h01, 1'b1, 2'd2, 1'b0, 32'h0010, 1'b1, 32'hFFFFFFF0, 2'd0, 1'b1, 1'b1},
    '{32'h0800, 32'h08, 12'h000, 5'h1A, 1'b1, 2'd2, 1'b0, 32'h0808, 1'b1, 32'h0808, 2'd0, 1'b0, 1'b0},
    '{32'h0050, 32'h00, 12'h0F0, 5'h17, 1'b1, 2'd0, 1'b0, 32'h0050, 1'b1, 32'h0050, 2'd1, 1'b0, 1'b1},
    '{32'hFFFFFFF0, 32'h20, 12'h000, 5'h18, 1'b0, 2'd0, 1'b1, 32'h0010, 1'b0, 32'h0010, 2'd2, 1'b0, 1'b0}
  };
  localparam string RTAG [NR] = '{"R2", "R3", "R4", "R5", "R6", "R6", "R5", "R3"};

  logic        req_valid_i = 0, rsp_ready_i = 1, ld_valid_i = 0, ldo_ready_i = 1;
  logic        req_ready_o, rsp_valid_o, ld_ready_o, ldo_valid_o;
  logic [31:0] req_base_i = 0, req_roff_i = 0, ld_word_i = 0;
  logic [11:0] req_imm_i = 0;
  logic [4:0]  req_ctrl_i = 0;
  logic        req_fam_i = 0, req_rsel_i = 0, ld_sext_i = 0;
  logic [1:0]  req_kind_i = 0, ld_lane_i = 0, ld_size_i = 0;
  logic [31:0] rsp_addr_o, rsp_wb_val_o, ldo_data_o;
  logic        rsp_wb_en_o, rsp_sext_o, rsp_load_o;
  logic [1:0]  rsp_size_o;

  ls_addr_gen u_ls_addr_gen (.*);

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic rv_t model(input rv_t v);
    rv_t r = v;
    logic [31:0] off, sum;
    if (v.fam) off = v.ctrl[2] ? {24'd0, v.imm[11:8], v.imm[3:0]} : v.roff;
    else       off = v.rsel ? v.roff : {20'd0, v.imm};
    sum       = v.ctrl[3] ? v.base + off : v.base - off;
    r.e_addr  = v.ctrl[4] ? sum : v.base;
    r.e_wben  = !v.ctrl[4] || v.ctrl[1];
    r.e_wbval = sum;
    r.e_size  = v.fam ? ((v.kind == 2'd2) ? 2'd0 : 2'd1) : (v.ctrl[2] ? 2'd0 : 2'd2);
    r.e_sext  = v.ctrl[0] && v.fam && v.kind[1];
    r.e_load  = v.ctrl[0];
    return r;
  endfunction

  task automatic drive_req(input rv_t v);
    req_base_i = v.base; req_roff_i = v.roff; req_imm_i = v.imm; req_ctrl_i = v.ctrl;
    req_fam_i = v.fam; req_kind_i = v.kind; req_rsel_i = v.rsel; req_valid_i = 1'b1;
  endtask

  task automatic check_rsp(input string tag, input rv_t v);
    chk({tag, " valid"}, {31'd0, rsp_valid_o}, 32'd1);
    chk({tag, " addr"}, rsp_addr_o, v.e_addr);
    chk({tag, " wb_en"}, {31'd0, rsp_wb_en_o}, {31'd0, v.e_wben});
    chk({tag, " wb_val"}, rsp_wb_val_o, v.e_wbval);
    chk({tag, " size"}, {30'd0, rsp_size_o}, {30'd0, v.e_size});
    chk({tag, " sext"}, {31'd0, rsp_sext_o}, {31'd0, v.e_sext});
    chk({tag, " load"}, {31'd0, rsp_load_o}, {31'd0, v.e_load});
  endtask

  task automatic send_req(input string tag, input rv_t v);
    @(negedge clk);
    rsp_ready_i = 1'b1;
    drive_req(v);
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    check_rsp(tag, v);
  endtask

  task automatic send_ld(input string tag, input logic [31:0] w, input logic [1:0] lane,
                         input logic [1:0] sz, input logic sx, input logic [31:0] exp);
    @(negedge clk);
    ldo_ready_i = 1'b1;
    ld_word_i = w; ld_lane_i = lane; ld_size_i = sz; ld_sext_i = sx; ld_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ld_valid_i = 1'b0;
    chk({tag, " ld valid"}, {31'd0, ldo_valid_o}, 32'd1);
    chk({tag, " ld data"}, ldo_data_o, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rv_t a, b;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 rsp_valid in reset", {31'd0, rsp_valid_o}, 32'd0);
    chk("R11 ldo_valid in reset", {31'd0, ldo_valid_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 req_ready idle", {31'd0, req_ready_o}, 32'd1);
    chk("R10 ld_ready idle", {31'd0, ld_ready_o}, 32'd1);

    // directed vector table
    for (int i = 0; i < NR; i++) send_req({RTAG[i], " table"}, RTBL[i]);

    // every control encoding, both families, both offset sources (R1 R2 R3 R4 R5 R6)
    for (int c = 0; c < 32; c++) begin
      for (int f = 0; f < 2; f++) begin
        for (int s = 0; s < 2; s++) begin
          rv_t v;
          v = '0;
          v.base = 32'h1000_0000 + 32'(c) * 32'h111;
          v.roff = 32'h40 + 32'(c);
          v.imm  = 12'h5A3;
          v.ctrl = 5'(c);
          v.fam  = f[0];
          v.rsel = s[0];
          v.kind = s[0] ? 2'd3 : 2'd1;
          send_req(c[4] ? "R2 sweep" : "R1 sweep", model(v));
        end
      end
    end

    // load extension table (R8 R9)
    send_ld("R8 byte lane0",  32'h80FF7F01, 2'd0, 2'd0, 1'b1, 32'h00000001);
    send_ld("R9 byte lane1",  32'h80FF7F01, 2'd1, 2'd0, 1'b1, 32'h0000007F);
    send_ld("R9 byte lane2",  32'h80FF7F01, 2'd2, 2'd0, 1'b1, 32'hFFFFFFFF);
    send_ld("R8 byte zext",   32'h80FF7F01, 2'd3, 2'd0, 1'b0, 32'h00000080);
    send_ld("R9 byte lane3",  32'h80FF7F01, 2'd3, 2'd0, 1'b1, 32'hFFFFFF80);
    send_ld("R9 half hi",     32'h80FF7F01, 2'd2, 2'd1, 1'b1, 32'hFFFF80FF);
    send_ld("R9 half lo pos", 32'h80FF7F01, 2'd0, 2'd1, 1'b1, 32'h00007F01);
    send_ld("R8 half zext",   32'h80FF7F01, 2'd3, 2'd1, 1'b0, 32'h000080FF);
    send_ld("R8 word",        32'h80FF7F01, 2'd1, 2'd2, 1'b1, 32'h80FF7F01);

    // R7: back-pressure hold and hand-over on the same edge
    a = RTBL[0];
    b = RTBL[3];
    @(negedge clk);
    rsp_ready_i = 1'b0;
    drive_req(a);
    @(posedge clk);
    @(negedge clk);
    drive_req(b);
    chk("R7 ready low when stalled", {31'd0, req_ready_o}, 32'd0);
    check_rsp("R7 stalled A", a);
    @(posedge clk);
    @(negedge clk);
    check_rsp("R7 held A", a);
    rsp_ready_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    check_rsp("R7 B after release", b);

    // R10: load stall hold
    @(negedge clk);
    ldo_ready_i = 1'b0;
    ld_word_i = 32'h1234ABCD; ld_lane_i = 2'd0; ld_size_i = 2'd1; ld_sext_i = 1'b1; ld_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ld_word_i = 32'h0;
    chk("R10 ld_ready low when stalled", {31'd0, ld_ready_o}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 held data", ldo_data_o, 32'hFFFFABCD);
    ld_valid_i = 1'b0;
    ldo_ready_i = 1'b1;
    @(posedge clk);

    // R10: both paths accept in the same cycle
    @(negedge clk);
    drive_req(RTBL[4]);
    ld_word_i = 32'h80FF7F01; ld_lane_i = 2'd2; ld_size_i = 2'd0; ld_sext_i = 1'b1; ld_valid_i = 1'b1;
    chk("R10 both ready", {30'd0, req_ready_o, ld_ready_o}, 32'd3);
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    ld_valid_i = 1'b0;
    check_rsp("R10 concurrent req", RTBL[4]);
    chk("R10 concurrent ld", ldo_data_o, 32'hFFFFFFFF);
    @(posedge clk);
    @(negedge clk);
    chk("R10 drained", {30'd0, rsp_valid_o, ldo_valid_o}, 32'd0);

    finish_run();
  end
endmodule